// File: doc/BRIEF.md
# Extended 128-by-64 Iterative Divider

This block performs an extended integer division for a processor's execute stage. The 64-bit operand A is used as the upper half of a 128-bit dividend whose lower half is zero, so the quotient computed is (A * 2^64) / B. The divisor B is 64 bits wide. One mode input selects signed or unsigned arithmetic. The block delivers a 64-bit quotient, a 64-bit remainder and an overflow flag.

Operands enter through a valid/ready pair. The block accepts an operation on a rising clock edge where `start_valid` and `start_ready` are both high. `start_ready` is low for as long as an operation is running, so the source must hold its request until it sees ready. A request made while ready is low is not taken.

Two cases are detected when the operands are accepted, and both finish at once with the overflow flag set: a zero divisor, and an upper dividend half whose magnitude is at least that of the divisor. Any other operation runs one restoring shift-subtract step per clock for 64 clocks. Signs are removed from the operands before these steps and put back onto the results after them. The result has no back-pressure. `done` is a single-cycle strobe, and the three result outputs keep their values until the next operation completes.

Top module: `div_ext`

## Requirements
- R1: After reset, `start_ready` is 1 and `busy`, `done`, `overflow`, `quotient` and `remainder` are all 0.
- R2: A divisor of zero sets `overflow`, forces `quotient` and `remainder` to 0, and raises `done` one edge after the accepting edge without `busy` ever going high.
- R3: In unsigned mode (`is_signed`=0), if A >= B with B nonzero, the result is `overflow`=1 with a zero quotient and zero remainder, and `done` rises one edge after acceptance.
- R4: In unsigned mode with A < B, `quotient` is floor(A*2^64/B), `remainder` is (A*2^64) mod B and `overflow` is 0. `busy` is high for exactly 64 clock cycles, and `done` rises on the 64th edge after the accepting edge.
- R5: In signed mode (`is_signed`=1, two's-complement operands), the quotient is rounded toward zero. A nonzero remainder carries the sign of A.
- R6: In signed mode, `overflow` is 1 when the true quotient lies outside [-2^63, 2^63-1] or B is zero. The magnitude pre-check catches some of these cases and the sign of the finished quotient catches the rest. In every overflow case `quotient` and `remainder` are 0.
- R7: `done` is high for one cycle per completed operation. `quotient`, `remainder` and `overflow` do not change until the next completion.
- R8: A `start_valid` that arrives while an operation is running is ignored: `start_ready` stays 0, the running result is unchanged, and no extra `done` follows.
- R9: `start_ready` is the inverse of `busy`, and `busy` rises only on an edge where a request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request: operands and mode are valid |
| start_ready | output | 1 | Block can accept a request |
| is_signed | input | 1 | 1 = two's-complement mode, 0 = unsigned |
| op_a | input | 64 | Upper half of the dividend (lower half is zero) |
| op_b | input | 64 | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle strobe: results updated |
| quotient | output | 64 | Quotient, zero on overflow |
| remainder | output | 64 | Remainder, zero on overflow |
| overflow | output | 1 | Quotient not representable, or divisor zero |

## Verification
The bench attacks the operand pairs where a shortcut would break. One is a zero divisor, where a design lacking the guard would either iterate into garbage or leave a stale quotient. Another is an upper half exactly equal to the divisor, where a strict greater-than test would let a 65-bit quotient wrap silently. Signed operands with a most-negative value are also covered: (-2^62, -2^63) produces a quotient of +2^63 that only the sign test catches, and its mirror (2^62, -2^63) must yield exactly -2^63 with no overflow, so a design that drops the sign test, or applies it to zero and exact-boundary quotients, fails one or the other. Requests made during a run check that a design does not accept them and corrupt the running result.

// File: rtl/div_ext_pkg.sv
package div_ext_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;

endpackage

// File: rtl/div_ext_pre.sv
// Operand conditioning: strips signs from the 2W-bit dividend and the divisor
// and predicts quotient overflow before any iteration.
module div_ext_pre #(
  parameter int W = 64
) (
  input  logic         is_signed,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi_mag,
  output logic [W-1:0] lo_mag,
  output logic [W-1:0] b_mag,
  output logic         a_neg,
  output logic         b_neg,
  output logic         pre_ovf
);

  localparam logic [W-1:0] LO_HALF = '0;

  logic         lo_carry;
  logic [W-1:0] lo_negated;
  logic [W-1:0] hi_negated;

  assign a_neg = is_signed & a_hi[W-1];
  assign b_neg = is_signed & b[W-1];

  // Two's-complement of {a_hi, LO_HALF}: the low half is inverted and
  // incremented, and its carry out feeds the inverted high half.
  assign {lo_carry, lo_negated} = {1'b0, ~LO_HALF} + {{W{1'b0}}, 1'b1};
  assign hi_negated = ~a_hi + {{(W-1){1'b0}}, lo_carry};

  assign hi_mag = a_neg ? hi_negated : a_hi;
  assign lo_mag = a_neg ? lo_negated : LO_HALF;
  assign b_mag  = b_neg ? (~b + 1'b1) : b;

  // A zero divisor, or a high half not below the divisor, gives a quotient
  // magnitude of 2^W or more.
  assign pre_ovf = (b == '0) | (hi_mag >= b_mag);

endmodule

// File: rtl/div_ext_step.sv
// One restoring shift-subtract step on the {hi, lo} partial remainder pair.
module div_ext_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] hi_next,
  output logic [W-1:0] lo_next
);

  logic         msb_out;
  logic [W-1:0] shifted;
  logic         take;

  assign msb_out = hi[W-1];
  assign shifted = {hi[W-2:0], lo[W-1]};
  assign take    = msb_out | (shifted >= dvs);
  assign hi_next = take ? (shifted - dvs) : shifted;
  assign lo_next = {lo[W-2:0], take};

endmodule

// File: rtl/div_ext_post.sv
// Restores result signs, applies the late signed overflow test and zeroes
// the result on overflow.
module div_ext_post #(
  parameter int W = 64
) (
  input  logic         is_signed,
  input  logic         a_neg,
  input  logic         b_neg,
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out,
  output logic         ovf
);

  logic         q_neg_exp;
  logic [W-1:0] q_signed;
  logic [W-1:0] r_signed;

  assign q_neg_exp = a_neg ^ b_neg;
  assign q_signed  = q_neg_exp ? (~q_mag + 1'b1) : q_mag;
  assign r_signed  = a_neg ? (~r_mag + 1'b1) : r_mag;

  // A nonzero quotient whose sign bit disagrees with the expected sign did
  // not fit the signed range.
  assign ovf   = is_signed & (q_signed != '0) & (q_signed[W-1] != q_neg_exp);
  assign q_out = ovf ? '0 : q_signed;
  assign r_out = ovf ? '0 : r_signed;

endmodule

// File: rtl/div_ext.sv
module div_ext
  import div_ext_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic         is_signed,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         overflow
);

  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] hi_q, lo_q, dvs_q;
  logic         sgn_q, aneg_q, bneg_q;
  logic [W-1:0] quo_q, rem_q;
  logic         ovf_q, done_q;

  logic [W-1:0] pre_hi, pre_lo, pre_b;
  logic         pre_an, pre_bn, pre_ovf;
  logic [W-1:0] stp_hi, stp_lo;
  logic [W-1:0] fin_q, fin_r;
  logic         fin_ovf;
  logic         accept;

  assign busy        = (state_q == ST_RUN);
  assign start_ready = ~busy;
  assign accept      = start_valid & start_ready;

  div_ext_pre #(.W(W)) u_pre (
    .is_signed (is_signed),
    .a_hi      (op_a),
    .b         (op_b),
    .hi_mag    (pre_hi),
    .lo_mag    (pre_lo),
    .b_mag     (pre_b),
    .a_neg     (pre_an),
    .b_neg     (pre_bn),
    .pre_ovf   (pre_ovf)
  );

  div_ext_step #(.W(W)) u_step (
    .hi      (hi_q),
    .lo      (lo_q),
    .dvs     (dvs_q),
    .hi_next (stp_hi),
    .lo_next (stp_lo)
  );

  div_ext_post #(.W(W)) u_post (
    .is_signed (sgn_q),
    .a_neg     (aneg_q),
    .b_neg     (bneg_q),
    .q_mag     (stp_lo),
    .r_mag     (stp_hi),
    .q_out     (fin_q),
    .r_out     (fin_r),
    .ovf       (fin_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      dvs_q   <= '0;
      sgn_q   <= 1'b0;
      aneg_q  <= 1'b0;
      bneg_q  <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (pre_ovf) begin
              quo_q  <= '0;
              rem_q  <= '0;
              ovf_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              cnt_q   <= '0;
              hi_q    <= pre_hi;
              lo_q    <= pre_lo;
              dvs_q   <= pre_b;
              sgn_q   <= is_signed;
              aneg_q  <= pre_an;
              bneg_q  <= pre_bn;
            end
          end
        end
        ST_RUN: begin
          hi_q  <= stp_hi;
          lo_q  <= stp_lo;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            quo_q   <= fin_q;
            rem_q   <= fin_r;
            ovf_q   <= fin_ovf;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/div_ext_chk.sv
module div_ext_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_valid,
  input logic         start_ready,
  input logic         is_signed,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         overflow,
  input logic         sgn_q,
  input logic         aneg_q
);

  localparam int LW = $clog2(W + 1) + 1;

  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R2: a zero divisor finishes at the next edge with overflow
  p_div_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && op_b == '0) |=> (done && overflow && !busy));

  // R3: unsigned upper half not below the divisor overflows immediately
  p_early_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && !is_signed && op_b != '0 && op_a >= op_b)
      |=> (done && overflow && !busy));

  // R4: every run lasts exactly W cycles
  p_run_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == LW'(W)));

  // R5: a nonzero signed remainder takes the sign of the dividend
  p_rem_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !overflow && sgn_q && remainder != '0) |-> (remainder[W-1] == aneg_q));

  // R6: overflow zeroes both results
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> (quotient == '0 && remainder == '0));

  // R7: results only move on completion
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(overflow)));

  // R8: no request is taken during a run
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ready);

  // R9: busy rises only after an accepted request
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid && start_ready));

  // R7: completion and running are exclusive
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind div_ext div_ext_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .is_signed   (is_signed),
  .op_a        (op_a),
  .op_b        (op_b),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .overflow    (overflow),
  .sgn_q       (sgn_q),
  .aneg_q      (aneg_q)
);

// File: tb/div_ext_bench.sv
`timescale 1ns/1ps
module div_ext_bench;

  localparam int W  = 64;
  localparam int NV = 20;

  // {is_signed, A, B}
  localparam logic [128:0] VEC [NV] = '{
    {1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002},
    {1'b0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007},
    {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0003},
    {1'b0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0003},
    {1'b0, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0003},
    {1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000},
    {1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002},
    {1'b1, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE},
    {1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0007},
    {1'b1, 64'h0000_0000_0000_0005, 64'hFFFF_FFFF_FFFF_FFF9},
    {1'b1, 64'hC000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b1, 64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
    {1'b1, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0003}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_valid;
  logic         start_ready;
  logic         is_signed;
  logic [W-1:0] op_a, op_b;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;
  logic         overflow;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  div_ext #(.W(W)) u_div_ext (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .is_signed   (is_signed),
    .op_a        (op_a),
    .op_b        (op_b),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .overflow    (overflow)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent 128-bit reference.
  function automatic void ref_div(input logic sgn, input logic [W-1:0] a, input logic [W-1:0] b,
                                  output logic [W-1:0] q, output logic [W-1:0] r,
                                  output logic ov);
    logic        [127:0] du, qu, ru;
    logic signed [127:0] ds, bs, qs, rs;
    q = '0; r = '0; ov = 1'b0;
    if (b == '0) begin
      ov = 1'b1;
    end else if (!sgn) begin
      du = {a, 64'h0};
      qu = du / {64'h0, b};
      ru = du % {64'h0, b};
      ov = (qu[127:64] != '0);
      q  = qu[63:0];
      r  = ru[63:0];
    end else begin
      ds = {a, 64'h0};
      bs = {{64{b[63]}}, b};
      qs = ds / bs;
      rs = ds % bs;
      ov = (qs > $signed(128'h0000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF)) ||
           (qs < $signed(128'hFFFF_FFFF_FFFF_FFFF_8000_0000_0000_0000)) ||
           (a == 64'h8000_0000_0000_0000 && b == 64'hFFFF_FFFF_FFFF_FFFF);
      q  = qs[63:0];
      r  = rs[63:0];
    end
    if (ov) begin
      q = '0;
      r = '0;
    end
  endfunction

  // Issue one request, wait for done, check latency, results, pulse and hold.
  task automatic run_op(input logic sgn, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
    logic [W-1:0] eq, er;
    logic         eov;
    int           lat;
    int           exp_lat;
    ref_div(sgn, a, b, eq, er, eov);
    exp_lat = (b == '0 || eov && ((sgn ? (a[63] ? -a : a) : a) >= (sgn ? (b[63] ? -b : b) : b)))
              ? 1 : W + 1;
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    is_signed   = sgn;
    op_a        = a;
    op_b        = b;
    @(negedge clk);
    start_valid = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    // R2 R3 R4: latency (early exit vs full run)
    chk({tag, " R4 latency"}, W'(lat), W'(exp_lat));
    // R4 R5 R6: values
    chk({tag, " R4/R5 quotient"}, quotient, eq);
    chk({tag, " R4/R5 remainder"}, remainder, er);
    chk({tag, " R6 overflow"}, W'(overflow), W'(eov));
    @(negedge clk);
    // R7: single-cycle strobe, values held
    chk({tag, " R7 done pulse"}, W'(done), '0);
    chk({tag, " R7 hold quotient"}, quotient, eq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    start_valid = 1'b0;
    is_signed   = 1'b0;
    op_a        = '0;
    op_b        = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 start_ready", W'(start_ready), W'(1));
    chk("R1 busy", W'(busy), '0);
    chk("R1 done", W'(done), '0);
    chk("R1 overflow", W'(overflow), '0);
    chk("R1 quotient", quotient, '0);
    chk("R1 remainder", remainder, '0);

    // Table walk: R2 R3 R4 R5 R6 corners
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][128], VEC[i][127:64], VEC[i][63:0], $sformatf("vec%0d", i));
    end

    // R4: hand-computed value, 2^64/2 = 2^63
    run_op(1'b0, 64'h1, 64'h2, "R4 fixed");
    chk("R4 fixed quotient", quotient, 64'h8000_0000_0000_0000);

    // R6: (2^62 << 64) / -2^63 = -2^63 exactly, must not overflow
    run_op(1'b1, 64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000, "R6 edge");
    chk("R6 edge quotient", quotient, 64'h8000_0000_0000_0000);
    chk("R6 edge no overflow", W'(overflow), '0);

    // Random operands, both modes
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] ra, rb;
      rb = {$urandom, $urandom};
      ra = {$urandom, $urandom} >> ($urandom % 64);
      run_op(i[0], ra, rb, $sformatf("rnd%0d", i));
    end

    // R8: requests during a run are ignored
    begin
      logic [W-1:0] eq, er;
      logic         eov;
      int           extra;
      ref_div(1'b0, 64'h1, 64'h3, eq, er, eov);
      start_valid = 1'b1;
      is_signed   = 1'b0;
      op_a        = 64'h1;
      op_b        = 64'h3;
      @(negedge clk);
      op_a = 64'h7;
      op_b = 64'h0;
      for (int k = 0; k < 10; k++) begin
        chk("R8 ready low while busy", W'(start_ready), '0);
        chk("R8 no early done", W'(done), '0);
        @(negedge clk);
      end
      start_valid = 1'b0;
      while (!done) @(negedge clk);
      chk("R8 result unaffected quotient", quotient, eq);
      chk("R8 result unaffected overflow", W'(overflow), W'(eov));
      extra = 0;
      @(negedge clk);
      for (int k = 0; k < 70; k++) begin
        if (done) extra++;
        @(negedge clk);
      end
      chk("R8 no extra done", W'(extra), '0);
      // R9: idle again
      chk("R9 ready after run", W'(start_ready), W'(1));
      chk("R9 busy low after run", W'(busy), '0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule